// File: doc/BRIEF.md
# OR/XOR Accumulating Register

This block is a register of parameterized width built from identical one-bit cells. On every clock edge each cell either keeps its bit, merges the matching data bit into it by OR, or toggles it by XOR with the matching data bit. The choice comes from two separate control lines, one for the OR merge and one for the XOR toggle. With both lines low, the register holds its value.

Each cell computes its next value from one minimized equation: next = (orLine AND d) OR (bit XOR (xorLine AND d)). The flip-flop is written on every clock, so it needs no enable and no source multiplexer in front of it. The two control lines must never be high in the same cycle. The register content drives the output directly.

A thin top module joins two parts. A control decoder turns the two lines into a strobe struct, and a datapath holds the generated array of cells. Typical uses are sticky flag collection (OR) and parity or mask toggling (XOR).

Top module: `orxor_accum_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `accOut` becomes 0 on that edge, whatever the control and data inputs are.
- R2: With `ctlOr`=0 and `ctlXor`=0 at a rising edge, `accOut` keeps its value across that edge for any `dataIn`.
- R3: With `ctlOr`=1 and `ctlXor`=0 at a rising edge, `accOut` becomes the bitwise OR of its previous value and `dataIn`.
- R4: With `ctlXor`=1 and `ctlOr`=0 at a rising edge, `accOut` becomes the bitwise XOR of its previous value and `dataIn`.
- R5: An update appears on `accOut` at the same rising edge that samples the controls, one register stage and no more. Before that edge `accOut` still shows the old value.
- R6: `ctlOr` and `ctlXor` are never both 1 in a cycle outside reset. The input rule is monitored.
- R7: Each bit i of `accOut` depends only on bit i of `dataIn` and on its own previous value, for every one of the WIDTH positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctlOr | input | 1 | Select the OR merge for this cycle |
| ctlXor | input | 1 | Select the XOR toggle for this cycle |
| dataIn | input | WIDTH | Operand bits, one per cell |
| accOut | output | WIDTH | Register content |

## Verification
Hold cycles use changing data to show that data cannot leak in without a control line. OR cycles with walking ones build up set bits that stay set, which separates OR from a plain load. Repeated XOR with the same word restores the first value, and XOR over set bits clears them, which separates XOR from OR. A long run of random legal control and data words is compared every cycle against an enable-plus-multiplexer model of the same transfers, and a reset issued with active inputs shows that reset wins.

// File: rtl/orxor_accum_pkg.sv
package orxor_accum_pkg;

  typedef struct packed {
    logic orStb;
    logic xorStb;
  } accStrobe_t;

endpackage

// File: rtl/orxor_accum_ctrl.sv
module orxor_accum_ctrl
  import orxor_accum_pkg::*;
(
  input  logic       ctlOr,
  input  logic       ctlXor,
  output accStrobe_t strobes
);

  always_comb begin
    strobes.orStb  = ctlOr;
    strobes.xorStb = ctlXor;
  end

endmodule

// File: rtl/orxor_accum_cell.sv
module orxor_accum_cell (
  input  logic clk,
  input  logic rst,
  input  logic orStb,
  input  logic xorStb,
  input  logic dBit,
  output logic qBit
);

  logic nextBit;

  // minimized next-state form; flip-flop written every cycle
  always_comb begin
    nextBit = (orStb & dBit) | (qBit ^ (xorStb & dBit));
  end

  always_ff @(posedge clk) begin
    if (rst) qBit <= 1'b0;
    else     qBit <= nextBit;
  end

endmodule

// File: rtl/orxor_accum_dpath.sv
module orxor_accum_dpath
  import orxor_accum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  accStrobe_t       strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] regQ
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    orxor_accum_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .orStb  (strobes.orStb),
      .xorStb (strobes.xorStb),
      .dBit   (dataIn[i]),
      .qBit   (regQ[i])
    );
  end

endmodule

// File: rtl/orxor_accum_reg.sv
module orxor_accum_reg
  import orxor_accum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctlOr,
  input  logic             ctlXor,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] accOut
);

  accStrobe_t strobes;

  orxor_accum_ctrl u_ctrl (
    .ctlOr   (ctlOr),
    .ctlXor  (ctlXor),
    .strobes (strobes)
  );

  orxor_accum_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .dataIn  (dataIn),
    .regQ    (accOut)
  );

endmodule

// File: rtl/orxor_accum_checker.sv
module orxor_accum_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctlOr,
  input logic             ctlXor,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] accOut
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (accOut == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctlOr && !ctlXor) |=> $stable(accOut));

  assert_or_merge_R3: assert property (@(posedge clk) disable iff (rst)
    (ctlOr && !ctlXor) |=> (accOut == ($past(accOut) | $past(dataIn))));

  assert_xor_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (ctlXor && !ctlOr) |=> (accOut == ($past(accOut) ^ $past(dataIn))));

  assert_legal_ctl_R6: assert property (@(posedge clk) disable iff (rst)
    !(ctlOr && ctlXor));

endmodule

bind orxor_accum_reg orxor_accum_checker #(.WIDTH(WIDTH)) u_checker (
  .clk    (clk),
  .rst    (rst),
  .ctlOr  (ctlOr),
  .ctlXor (ctlXor),
  .dataIn (dataIn),
  .accOut (accOut)
);

// File: tb/orxor_accum_reg_bench.sv
`timescale 1ns/1ps
module orxor_accum_reg_bench;

  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ctlOr = 1'b0;
  logic             ctlXor = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] accOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [WIDTH-1:0] model = '0;

  always #10 clk = ~clk;

  orxor_accum_reg #(.WIDTH(WIDTH)) u_orxor_accum_reg (
    .clk(clk), .rst(rst), .ctlOr(ctlOr), .ctlXor(ctlXor),
    .dataIn(dataIn), .accOut(accOut)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] exp);
    total++;
    if (accOut !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, accOut, exp);
    end
  endtask

  // enable-plus-multiplexer reference: load when either line is high
  function automatic logic [WIDTH-1:0] refNext(input logic o, input logic x,
      input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    logic load;
    load = o | x;
    if (!load) return a;
    if (o) return a | b;
    return a ^ b;
  endfunction

  // drive at negedge, one edge, check at next negedge
  task automatic step(input logic o, input logic x, input logic [WIDTH-1:0] b,
                      input string req);
    ctlOr = o; ctlXor = x; dataIn = b;
    model = refNext(o, x, model, b);
    @(posedge clk);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", '0);
    rst = 1'b0;

    // R5: before the edge the old value still shows
    ctlOr = 1'b1; ctlXor = 1'b0; dataIn = 8'h81;
    #2;
    check("R5 no early change", '0);
    model = refNext(1'b1, 1'b0, model, 8'h81);
    @(posedge clk); @(negedge clk);
    check("R5 one edge latency", model);

    // R2: hold with changing data
    step(1'b0, 1'b0, 8'hFF, "R2 hold ff");
    step(1'b0, 1'b0, 8'h5A, "R2 hold 5a");
    step(1'b0, 1'b0, 8'h00, "R2 hold 00");

    // R3 and R7: walking ones accumulate
    for (int i = 0; i < WIDTH; i++)
      step(1'b1, 1'b0, 8'h01 << i, "R3 R7 or walking one");
    check("R3 all bits set", 8'hFF);

    // R4: XOR over set bits clears them
    step(1'b0, 1'b1, 8'hF0, "R4 xor clears");
    check("R4 value 0f", 8'h0F);
    step(1'b0, 1'b1, 8'h3C, "R4 xor toggle");
    step(1'b0, 1'b1, 8'h3C, "R4 xor restore");
    check("R4 restored 0f", 8'h0F);

    // R7: walking one XOR toggles single bits
    for (int i = 0; i < WIDTH; i++)
      step(1'b0, 1'b1, 8'h01 << i, "R7 xor walking one");

    // alternating patterns
    step(1'b0, 1'b1, 8'h55, "R4 xor 55");
    step(1'b1, 1'b0, 8'hAA, "R3 or aa");
    step(1'b0, 1'b1, 8'hAA, "R4 xor aa");

    // random legal sequence against the reference
    for (int i = 0; i < 300; i++) begin
      int sel;
      logic [WIDTH-1:0] b;
      sel = $urandom_range(0, 2);
      b = WIDTH'($urandom);
      case (sel)
        0: step(1'b0, 1'b0, b, "R2 random hold");
        1: step(1'b1, 1'b0, b, "R3 random or");
        default: step(1'b0, 1'b1, b, "R4 random xor");
      endcase
    end

    // R1: reset wins over active inputs
    step(1'b1, 1'b0, 8'hC3, "R3 before reset");
    rst = 1'b1; ctlOr = 1'b1; dataIn = 8'hFF;
    @(posedge clk); @(negedge clk);
    model = '0;
    check("R1 reset with active or", '0);
    rst = 1'b0;
    step(1'b0, 1'b1, 8'h42, "R4 after reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule